// File: doc/BRIEF.md
# Two-Level Reconfigurable DSP ALU Slice

This block is one 16-bit arithmetic slice of a coarse-grained reconfigurable array. Each of its four operand lanes owns a private four-entry register file, and the arithmetic only ever reads from these files. A configuration word, supplied with a valid strobe, picks the register-file entries, the first-stage operation, the second-stage mode and the output selection.

The first stage combines operands A and B with a logic, shift, min/max or add/subtract operation. The second stage multiplies that result by operand C, either as a signed integer or as signed 1.15 fixed point. It then adds operand D, accumulates, or subtracts the product from a value arriving directly from the neighbouring slice on the east side. The slice drives a general result output and a west-facing output that carries the accumulator to the slice on its left.

The configuration word is 16 bits, packed from the most significant bit down as follows:

- [15:14] D entry
- [13:12] C entry
- [11:10] B entry
- [9:8] A entry
- [7:5] stage-1 opcode
- [4:3] stage-2 mode
- [2] fixed-point flag
- [1] accumulator clear
- [0] output select

Top module: `dsp_alu_slice`

## Requirements
- R1: After reset both outputs are zero and every register-file entry is zero.
- R2: A register-file write presented in the same cycle as, or before, a configuration word is seen by that operation. A write presented in the cycle after the word is not seen by it; that operation reads the old entry.
- R3: Stage-1 opcodes act on A and B, signed where it matters: 0 is A+B, 1 is A-B, 2 is A AND B, 3 is A OR B, 4 is the signed minimum, 5 is the signed maximum. Addition and subtraction wrap at 16 bits.
- R4: Opcode 6 shifts A left and opcode 7 shifts A right arithmetically, preserving the sign. The shift amount is B[3:0] and the upper bits of B are ignored.
- R5: With the fixed-point flag at 0, the multiply modes use the low 16 bits of the signed product of the stage-1 result and C.
- R6: With the fixed-point flag at 1, the product is bits [30:15] of the 32-bit signed product. The result saturates to 0x7FFF or 0x8000 when it does not fit, so that 0x8000 times 0x8000 gives 0x7FFF.
- R7: Stage-2 mode 0 outputs the stage-1 result plus D and leaves the accumulator unchanged unless the clear bit is set.
- R8: Mode 2 adds the product to the accumulator, or loads the product if the clear bit is set. Mode 1 outputs the product and leaves the accumulator unchanged, or zeroes it if the clear bit is set.
- R9: Mode 3 loads the accumulator with east_in minus the product and outputs the product.
- R10: With output select 0, res_out shows the stage-2 result; with 1, it shows the stage-1 result. west_out always shows the accumulator.
- R11: Results appear on the outputs after the third rising edge counted from the edge that samples the configuration word. Both outputs hold while no configuration word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 4 | Write enable per operand register file (bit 0 = A) |
| wr_addr | input | 8 | Write entry per file, 2 bits each, A in [1:0] |
| wr_data | input | 64 | Write data per file, 16 bits each, A in [15:0] |
| cfg_valid | input | 1 | Configuration word valid this cycle |
| cfg_word | input | 16 | Configuration word |
| east_in | input | 16 | Direct operand from the east neighbour |
| res_out | output | 16 | Selected result |
| west_out | output | 16 | Accumulator, to the west neighbour |

## Verification
The east-subtract property compares the accumulator with east_in one cycle after the second stage fires. It therefore assumes the neighbour holds east_in steady across that edge. The bench keeps east_in constant for the whole run, apart from one change made while the slice is idle.

The saturation and clear properties key on the pipeline's own stage registers, and the hold properties assume results move only when an operation is in flight. The bench therefore issues one configuration word at a time and waits for it to drain before the next.

// File: rtl/dsp_slice_pkg.sv
package dsp_slice_pkg;

   localparam int RF_DEPTH = 4;
   localparam int RSEL_W   = $clog2(RF_DEPTH);

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_MIN = 3'd4,
      OP_MAX = 3'd5,
      OP_SHL = 3'd6,
      OP_ASR = 3'd7
   } s1_op_e;

   typedef enum logic [1:0] {
      M_ADDD = 2'd0,
      M_MUL  = 2'd1,
      M_MAC  = 2'd2,
      M_ESUB = 2'd3
   } s2_mode_e;

   typedef struct packed {
      logic [RSEL_W-1:0] rsel_d;
      logic [RSEL_W-1:0] rsel_c;
      logic [RSEL_W-1:0] rsel_b;
      logic [RSEL_W-1:0] rsel_a;
      s1_op_e            op;
      s2_mode_e          mode;
      logic              fixp;
      logic              clr;
      logic              osel;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/slice_stage1.sv
module slice_stage1
   import dsp_slice_pkg::*;
#(
   parameter int W = 16,
   localparam int SH_W = $clog2(W)
) (
   input  s1_op_e       op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   logic [SH_W-1:0] amt;
   logic            a_lt_b;

   assign amt    = b[SH_W-1:0];
   assign a_lt_b = $signed(a) < $signed(b);

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_MIN:  y = a_lt_b ? a : b;
         OP_MAX:  y = a_lt_b ? b : a;
         OP_SHL:  y = a << amt;
         OP_ASR:  y = $signed(a) >>> amt;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/slice_stage2.sv
module slice_stage2
   import dsp_slice_pkg::*;
#(
   parameter int W = 16,
   localparam int PW = 2 * W
) (
   input  s2_mode_e     mode,
   input  logic         fixp,
   input  logic         clr,
   input  logic [W-1:0] s1,
   input  logic [W-1:0] c,
   input  logic [W-1:0] d,
   input  logic [W-1:0] east,
   input  logic [W-1:0] acc,
   output logic [W-1:0] res,
   output logic [W-1:0] acc_nxt
);

   localparam logic [W-1:0] SAT_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SAT_NEG = {1'b1, {(W-1){1'b0}}};

   logic signed [PW-1:0] prod;
   logic [W-1:0]         fix_res;
   logic [W-1:0]         mres;
   logic [W-1:0]         base;
   logic                 fix_ovf;

   assign prod    = $signed(s1) * $signed(c);
   assign fix_ovf = prod[PW-1] != prod[PW-2];
   assign fix_res = fix_ovf ? (prod[PW-1] ? SAT_NEG : SAT_POS) : prod[PW-2:W-1];
   assign mres    = fixp ? fix_res : prod[W-1:0];
   assign base    = clr ? '0 : acc;

   always_comb begin
      unique case (mode)
         M_ADDD: begin
            res     = s1 + d;
            acc_nxt = base;
         end
         M_MUL: begin
            res     = mres;
            acc_nxt = base;
         end
         M_MAC: begin
            res     = mres;
            acc_nxt = base + mres;
         end
         M_ESUB: begin
            res     = mres;
            acc_nxt = east - mres;
         end
         default: begin
            res     = '0;
            acc_nxt = acc;
         end
      endcase
   end

endmodule

// File: rtl/dsp_alu_slice.sv
module dsp_alu_slice
   import dsp_slice_pkg::*;
#(
   parameter int W      = 16,
   parameter int DEPTH  = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int NOPS  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NOPS-1:0]      wr_en,
   input  logic [NOPS*AW-1:0]   wr_addr,
   input  logic [NOPS*W-1:0]    wr_data,
   input  logic                 cfg_valid,
   input  logic [CFG_W-1:0]     cfg_word,
   input  logic [W-1:0]         east_in,
   output logic [W-1:0]         res_out,
   output logic [W-1:0]         west_out
);

   if (W < 8) begin : g_bad_width
      $error("dsp_alu_slice: W must be at least 8");
   end
   if (AW != RSEL_W) begin : g_bad_depth
      $error("dsp_alu_slice: DEPTH must match the configuration select width");
   end

   // configuration register
   cfg_t   cfg_q;
   logic   v1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q  <= 1'b0;
         cfg_q <= '0;
      end else begin
         v1_q <= cfg_valid;
         if (cfg_valid) cfg_q <= cfg_t'(cfg_word);
      end
   end

   // operand register files, never bypassed
   logic [AW-1:0] rsel  [NOPS];
   logic [W-1:0]  opnd  [NOPS];

   assign rsel[0] = cfg_q.rsel_a;
   assign rsel[1] = cfg_q.rsel_b;
   assign rsel[2] = cfg_q.rsel_c;
   assign rsel[3] = cfg_q.rsel_d;

   for (genvar g = 0; g < NOPS; g++) begin : g_rf
      slice_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en[g]),
         .waddr (wr_addr[g*AW +: AW]),
         .wdata (wr_data[g*W +: W]),
         .raddr (rsel[g]),
         .rdata (opnd[g])
      );
   end

   // stage 1
   s1_op_e       s1_op;
   logic [W-1:0] s1_res;

   assign s1_op = cfg_q.op;

   slice_stage1 #(.W(W)) u_s1 (
      .op (s1_op),
      .a  (opnd[0]),
      .b  (opnd[1]),
      .y  (s1_res)
   );

   logic         v2_q;
   logic [W-1:0] s1_q, c_q, d_q;
   s2_mode_e     mode_q;
   logic         fixp_q, clr_q, osel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2_q   <= 1'b0;
         s1_q   <= '0;
         c_q    <= '0;
         d_q    <= '0;
         mode_q <= M_ADDD;
         fixp_q <= 1'b0;
         clr_q  <= 1'b0;
         osel_q <= 1'b0;
      end else begin
         v2_q <= v1_q;
         if (v1_q) begin
            s1_q   <= s1_res;
            c_q    <= opnd[2];
            d_q    <= opnd[3];
            mode_q <= cfg_q.mode;
            fixp_q <= cfg_q.fixp;
            clr_q  <= cfg_q.clr;
            osel_q <= cfg_q.osel;
         end
      end
   end

   // stage 2
   logic [W-1:0] s2_res, acc_nxt, acc_q, res_q;

   slice_stage2 #(.W(W)) u_s2 (
      .mode    (mode_q),
      .fixp    (fixp_q),
      .clr     (clr_q),
      .s1      (s1_q),
      .c       (c_q),
      .d       (d_q),
      .east    (east_in),
      .acc     (acc_q),
      .res     (s2_res),
      .acc_nxt (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         acc_q <= '0;
      end else if (v2_q) begin
         res_q <= osel_q ? s1_q : s2_res;
         acc_q <= acc_nxt;
      end
   end

   assign res_out  = res_q;
   assign west_out = acc_q;

endmodule

// File: rtl/dsp_alu_slice_chk.sv
module dsp_alu_slice_chk
   import dsp_slice_pkg::*;
#(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         v1_q,
   input logic         v2_q,
   input s1_op_e       s1_op,
   input logic [W-1:0] opa,
   input logic [W-1:0] opb,
   input logic [W-1:0] s1_res,
   input s2_mode_e     mode_q,
   input logic         fixp_q,
   input logic         clr_q,
   input logic         osel_q,
   input logic [W-1:0] s1_q,
   input logic [W-1:0] c_q,
   input logic [W-1:0] east_in,
   input logic [W-1:0] res_out,
   input logic [W-1:0] west_out
);

   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   AST_IDLE_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !v2_q |=> $stable(res_out)); // R11

   AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !v2_q |=> $stable(west_out)); // R11

   AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (v1_q && s1_op == OP_MIN) |->
      ($signed(s1_res) <= $signed(opa) && $signed(s1_res) <= $signed(opb))); // R3

   AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (v1_q && s1_op == OP_MAX) |->
      ($signed(s1_res) >= $signed(opa) && $signed(s1_res) >= $signed(opb))); // R3

   AST_FIX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && fixp_q && mode_q == M_MUL && !osel_q && s1_q == MOST_NEG && c_q == MOST_NEG)
      |=> res_out == MOST_POS); // R6

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && clr_q && (mode_q == M_ADDD || mode_q == M_MUL)) |=> west_out == '0); // R8

   AST_EAST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && mode_q == M_ESUB && c_q == '0) |=> west_out == $past(east_in)); // R9

   AST_OSEL_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && osel_q) |=> res_out == $past(s1_q)); // R10

endmodule

bind dsp_alu_slice dsp_alu_slice_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .v1_q     (v1_q),
   .v2_q     (v2_q),
   .s1_op    (s1_op),
   .opa      (opnd[0]),
   .opb      (opnd[1]),
   .s1_res   (s1_res),
   .mode_q   (mode_q),
   .fixp_q   (fixp_q),
   .clr_q    (clr_q),
   .osel_q   (osel_q),
   .s1_q     (s1_q),
   .c_q      (c_q),
   .east_in  (east_in),
   .res_out  (res_out),
   .west_out (west_out)
);

// File: tb/dsp_alu_slice_tb.sv
`timescale 1ns/1ps
module dsp_alu_slice_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  wr_en = '0;
   logic [7:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic        cfg_valid = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [15:0] east_in = 16'd1000;
   logic [15:0] res_out, west_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dsp_alu_slice u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg_valid(cfg_valid), .cfg_word(cfg_word), .east_in(east_in),
      .res_out(res_out), .west_out(west_out)
   );

   // opcodes and modes as stated in the requirements
   localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3,
                          MIN = 3'd4, MAX = 3'd5, SHL = 3'd6, ASR = 3'd7;
   localparam logic [1:0] MD_ADDD = 2'd0, MD_MUL = 2'd1, MD_MAC = 2'd2, MD_ESUB = 2'd3;

   function automatic logic [15:0] mk(input logic [2:0] op, input logic [1:0] md,
                                      input logic fx, input logic cl, input logic os,
                                      input logic [1:0] ra, input logic [1:0] rb,
                                      input logic [1:0] rc, input logic [1:0] rd);
      return {rd, rc, rb, ra, op, md, fx, cl, os};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int f, input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 4'(1 << f);
      wr_addr[f*2 +: 2] = a;
      wr_data[f*16 +: 16] = d;
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic run(input logic [15:0] c, output logic [15:0] r, output logic [15:0] w);
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_word  = c;
      @(negedge clk);
      cfg_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      r = res_out;
      w = west_out;
   endtask

   task automatic t_reset;
      logic [15:0] r, w;
      chk("R1 res_out after reset", res_out, 16'h0);
      chk("R1 west_out after reset", west_out, 16'h0);
      run(mk(ADD, MD_ADDD, 0, 0, 1, 2'd3, 2'd3, 2'd3, 2'd3), r, w);
      chk("R1 register files cleared", r, 16'h0);
   endtask

   task automatic t_load;
      wr(0, 0, 16'd100);  wr(0, 1, 16'hFFEC); wr(0, 2, 16'h8000); wr(0, 3, 16'h4000);
      wr(1, 0, 16'd7);    wr(1, 1, 16'd3);    wr(1, 2, 16'h0013); wr(1, 3, 16'h0000);
      wr(2, 0, 16'd0);    wr(2, 1, 16'd3);    wr(2, 2, 16'h8000); wr(2, 3, 16'h4000);
      wr(3, 0, 16'd0);    wr(3, 1, 16'd5);
   endtask

   task automatic t_stage1;
      logic [15:0] r, w;
      run(mk(ADD,  MD_ADDD, 0, 0, 1, 0, 0, 0, 0), r, w); chk("R3 add", r, 16'd107);
      run(mk(SUB,  MD_ADDD, 0, 0, 1, 1, 0, 0, 0), r, w); chk("R3 sub", r, 16'hFFE5);
      run(mk(AND_, MD_ADDD, 0, 0, 1, 0, 0, 0, 0), r, w); chk("R3 and", r, 16'h0004);
      run(mk(OR_,  MD_ADDD, 0, 0, 1, 0, 0, 0, 0), r, w); chk("R3 or",  r, 16'h0067);
      run(mk(MIN,  MD_ADDD, 0, 0, 1, 1, 0, 0, 0), r, w); chk("R3 min", r, 16'hFFEC);
      run(mk(MAX,  MD_ADDD, 0, 0, 1, 1, 0, 0, 0), r, w); chk("R3 max", r, 16'd7);
   endtask

   task automatic t_shift;
      logic [15:0] r, w;
      run(mk(SHL, MD_ADDD, 0, 0, 1, 0, 1, 0, 0), r, w); chk("R4 shl by 3", r, 16'h0320);
      run(mk(ASR, MD_ADDD, 0, 0, 1, 1, 2, 0, 0), r, w); chk("R4 asr upper B bits ignored", r, 16'hFFFD);
      run(mk(ASR, MD_ADDD, 0, 0, 1, 2, 1, 0, 0), r, w); chk("R4 asr keeps sign", r, 16'hF000);
   endtask

   task automatic t_addd;
      logic [15:0] r, w;
      run(mk(ADD, MD_ADDD, 0, 0, 0, 0, 0, 0, 1), r, w);
      chk("R7 s1 plus D", r, 16'd112);
      chk("R7 accumulator untouched", w, 16'h0);
   endtask

   task automatic t_int_mul;
      logic [15:0] r, w;
      run(mk(ADD, MD_MUL, 0, 0, 0, 1, 0, 1, 0), r, w); chk("R5 negative integer product", r, 16'hFFD9);
      run(mk(ADD, MD_MUL, 0, 0, 0, 0, 0, 3, 0), r, w); chk("R5 low half of wide product", r, 16'hC000);
   endtask

   task automatic t_fix_mul;
      logic [15:0] r, w;
      run(mk(ADD, MD_MUL, 1, 0, 0, 2, 3, 2, 0), r, w); chk("R6 -1 times -1 saturates", r, 16'h7FFF);
      run(mk(ADD, MD_MUL, 1, 0, 0, 2, 3, 3, 0), r, w); chk("R6 -1 times 0.5", r, 16'hC000);
      run(mk(ADD, MD_MUL, 1, 0, 0, 3, 3, 3, 0), r, w); chk("R6 0.5 times 0.5", r, 16'h2000);
   endtask

   task automatic t_mac;
      logic [15:0] r, w;
      run(mk(ADD, MD_MAC, 0, 1, 0, 0, 0, 1, 0), r, w); chk("R8 mac with clear loads product", w, 16'd321);
      run(mk(ADD, MD_MAC, 0, 0, 0, 1, 0, 1, 0), r, w); chk("R8 mac accumulates", w, 16'd282);
      run(mk(ADD, MD_MUL, 0, 0, 0, 0, 0, 1, 0), r, w); chk("R8 mul keeps accumulator", w, 16'd282);
      chk("R8 mul output", r, 16'd321);
      run(mk(ADD, MD_MUL, 0, 1, 0, 0, 0, 1, 0), r, w); chk("R8 mul with clear zeroes accumulator", w, 16'd0);
   endtask

   task automatic t_esub;
      logic [15:0] r, w;
      run(mk(ADD, MD_ESUB, 0, 0, 0, 0, 0, 1, 0), r, w);
      chk("R9 east minus product", w, 16'd679);
      chk("R9 product on res_out", r, 16'd321);
   endtask

   task automatic t_osel;
      logic [15:0] r, w;
      run(mk(ADD, MD_MAC, 0, 0, 1, 0, 0, 1, 0), r, w);
      chk("R10 res_out shows stage 1", r, 16'd107);
      chk("R10 west_out shows accumulator", w, 16'd1000);
   endtask

   task automatic t_latency;
      logic [15:0] r0, w0;
      r0 = res_out;
      w0 = west_out;
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_word  = mk(SUB, MD_ADDD, 0, 0, 1, 0, 0, 0, 0);
      @(negedge clk);
      cfg_valid = 1'b0;
      chk("R11 unchanged after one edge", res_out, r0);
      @(negedge clk);
      chk("R11 unchanged after two edges", res_out, r0);
      @(negedge clk);
      chk("R11 result after three edges", res_out, 16'd93);
      east_in = 16'd5;
      repeat (6) @(negedge clk);
      chk("R11 res_out holds while idle", res_out, 16'd93);
      chk("R11 west_out holds while idle", west_out, w0);
      east_in = 16'd1000;
   endtask

   task automatic t_rf_timing;
      logic [15:0] r, w;
      // write and configuration in the same cycle
      @(negedge clk);
      wr_en = 4'b0001; wr_addr[1:0] = 2'd3; wr_data[15:0] = 16'h0011;
      cfg_valid = 1'b1; cfg_word = mk(ADD, MD_ADDD, 0, 0, 1, 3, 3, 0, 0);
      @(negedge clk);
      wr_en = '0; cfg_valid = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R2 same-cycle write is seen", res_out, 16'h0011);
      // write one cycle after the configuration word
      @(negedge clk);
      cfg_valid = 1'b1; cfg_word = mk(ADD, MD_ADDD, 0, 0, 1, 3, 3, 0, 0);
      @(negedge clk);
      cfg_valid = 1'b0;
      wr_en = 4'b0001; wr_addr[1:0] = 2'd3; wr_data[15:0] = 16'h0022;
      @(negedge clk);
      wr_en = '0;
      @(negedge clk);
      chk("R2 later write reads old entry", res_out, 16'h0011);
      run(mk(ADD, MD_ADDD, 0, 0, 1, 3, 3, 0, 0), r, w);
      chk("R2 later write visible to next op", r, 16'h0022);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_stage1();
      t_shift();
      t_addd();
      t_int_mul();
      t_fix_mul();
      t_mac();
      t_esub();
      t_osel();
      t_latency();
      t_rf_timing();
      finish_run();
   end

endmodule